// File: doc/BRIEF.md
# Single-Wire Bus Bit-Timing Master

This block is the timing engine of a host for an open-drain single-wire bus. A host hands it one command at a time over a valid/ready handshake. The commands are a bus reset with presence detect, a byte write, a byte read and a byte touch. A touch writes each bit and reports what the line showed during the same slot. Every slot is timed in microseconds, counted on an external one-microsecond tick. All phase budgets are multiplied by an integer coefficient. The block pulls the line low through an active-low drive enable. The line level comes back through a two-flop synchronizer and is sampled at a fixed point in each slot.

Bytes move least significant bit first. A read byte is built by placing each sampled bit at its own position. The host may also arm a one-shot strong pull-up with a duration in milliseconds. The next byte write or touch turns it on once its eighth slot releases the line, and holds it for that many milliseconds after the slot ends. The request is then spent. The block reports busy from command accept until the final slot, including its recovery time and any pull-up hold, has run out. A one-cycle response pulse then carries the result.

Top module: `owm_master`

## Requirements
- R1: A reset command (op code 0) holds bus_drive_low for 500×COEF microseconds, then samples the line 570×COEF microseconds after the slot start; rsp_data bit 0 is 0 when a device pulled the line low (present) and 1 when the line was high, other bits 0.
- R2: busy stays high for exactly n×(T×COEF+1) clock cycles when us_tick is high every cycle, where n is the slot count (1 for reset, 8 for a byte), T is 1000 us for a reset slot and 70 us for a bit slot; the reset slot's recovery spans at least 430 us after its sample point.
- R3: A bit slot that writes 1 holds the line low 6×COEF us, a slot that writes 0 holds it low 60×COEF us, and both last 70×COEF us in total.
- R4: A read command (op code 2) runs eight write-1 slots, samples each 15×COEF us after the slot start, and returns the samples in rsp_data with the first slot in bit 0.
- R5: A write command (op code 1) sends cmd_data least significant bit first, one slot per bit, and returns rsp_data = 0.
- R6: A touch command (op code 3) sends cmd_data like a write; each 1 bit reports its sample and each 0 bit reports 0 in the same bit position of rsp_data.
- R7: cmd_ready is low and cmd_valid is ignored from command accept until the command completes; busy is the inverse of cmd_ready.
- R8: rsp_valid pulses for one cycle, in the first cycle that busy is low after a command.
- R9: With a non-zero pull-up request pending, the next write or touch raises strong_pu when its eighth slot releases the line, keeps it high to that slot's end and then for pu_ms×US_PER_MS ticks, and extends busy by the same hold; strong_pu and bus_drive_low are never high together.
- R10: A pull-up request is one-shot. It is taken by pu_valid while the block is idle and no command is accepted in the same cycle. A write or touch spends it. A read or reset leaves it pending. A request of 0 ms cancels it.
- R11: All slot phase durations scale with the COEF parameter; with COEF=2 a write-0 slot holds the line low 120 us.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse per elapsed microsecond |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted (idle) |
| cmd_op | input | 2 | 0 reset, 1 write, 2 read, 3 touch |
| cmd_data | input | BYTE_W | Byte to write or touch |
| pu_valid | input | 1 | Load a strong pull-up request |
| pu_ms | input | PU_W | Pull-up duration in milliseconds, 0 cancels |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | BYTE_W | Result byte or presence bit |
| busy | output | 1 | Command in progress |
| bus_drive_low | output | 1 | 1 pulls the bus line low |
| bus_in | input | 1 | Bus line level, asynchronous |
| strong_pu | output | 1 | Strong pull-up enable |

## Verification
The assertions assume us_tick is the only time base, so no phase advances without it. They also assume the line level on bus_in can only be pulled low, by this block or by devices, and never driven high against a low drive. The slot engine is taken never to receive a start while a slot is running, and the sequencer must guarantee this. The stimulus holds us_tick high on every cycle so phase widths map directly to cycle counts. Its device model only pulls the line low inside the windows a real device would use. Commands and pull-up requests are driven on the falling clock edge.

// File: rtl/owm_pkg.sv
package owm_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_TOUCH = 2'd3
    } owm_op_e;

    typedef enum logic [1:0] {
        SLOT_ONE  = 2'd0,
        SLOT_ZERO = 2'd1,
        SLOT_RST  = 2'd2
    } owm_slot_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_PULL = 2'd2
    } owm_seq_e;

    // base budgets in microseconds, measured from slot start
    localparam int unsigned US_ONE_LOW    = 6;
    localparam int unsigned US_ZERO_LOW   = 60;
    localparam int unsigned US_BIT_SAMPLE = 15;
    localparam int unsigned US_BIT_TOTAL  = 70;
    localparam int unsigned US_RST_LOW    = 500;
    localparam int unsigned US_RST_SAMPLE = 570;
    localparam int unsigned US_RST_TOTAL  = 1000;

    typedef struct packed {
        logic [31:0] low;
        logic [31:0] smp;
        logic [31:0] total;
    } owm_timing_t;

    function automatic owm_timing_t slot_timing(owm_slot_e k, int unsigned coef);
        owm_timing_t r;
        case (k)
            SLOT_ZERO: begin
                r.low   = 32'(US_ZERO_LOW * coef);
                r.smp   = 32'(US_BIT_SAMPLE * coef);
                r.total = 32'(US_BIT_TOTAL * coef);
            end
            SLOT_RST: begin
                r.low   = 32'(US_RST_LOW * coef);
                r.smp   = 32'(US_RST_SAMPLE * coef);
                r.total = 32'(US_RST_TOTAL * coef);
            end
            default: begin
                r.low   = 32'(US_ONE_LOW * coef);
                r.smp   = 32'(US_BIT_SAMPLE * coef);
                r.total = 32'(US_BIT_TOTAL * coef);
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) ff <= '1;
                else     ff <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) ff <= '1;
                else     ff <= {ff[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = ff[STAGES-1];
endmodule

// File: rtl/owm_slot.sv
module owm_slot
    import owm_pkg::*;
#(
    parameter int unsigned COEF = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      us_tick,
    input  logic      start,
    input  owm_slot_e kind,
    input  logic      line_s,
    output logic      drive_low,
    output logic      active,
    output logic      done,
    output logic      smp_bit
);
    localparam int unsigned TW = $clog2(US_RST_TOTAL * COEF + 1);

    logic [TW-1:0] t;
    owm_slot_e     kind_q;
    owm_timing_t   tim;
    logic [TW-1:0] low_c, smp_c, end_c;

    always_comb begin
        tim   = slot_timing(kind_q, COEF);
        low_c = tim.low[TW-1:0];
        smp_c = TW'(tim.smp - 32'd1);
        end_c = TW'(tim.total - 32'd1);
    end

    assign drive_low = active && (t < low_c);
    assign done      = active && us_tick && (t == end_c);

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            t       <= '0;
            kind_q  <= SLOT_ONE;
            smp_bit <= 1'b1;
        end else if (start) begin
            active <= 1'b1;
            t      <= '0;
            kind_q <= kind;
        end else if (active && us_tick) begin
            t <= t + 1'b1;
            if (t == smp_c) smp_bit <= line_s;
            if (done) active <= 1'b0;
        end
    end

    // R2: the sequencer must never restart a slot that is still running
    p_no_overlap_r2: assert property (@(posedge clk) disable iff (rst)
        start |-> !active);

    // R3: a low phase only ever begins right after a start request
    p_low_after_start_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_low) |-> $past(start));
endmodule

// File: rtl/owm_master.sv
module owm_master
    import owm_pkg::*;
#(
    parameter int unsigned COEF      = 1,
    parameter int unsigned BYTE_W    = 8,
    parameter int unsigned PU_W      = 8,
    parameter int unsigned US_PER_MS = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              us_tick,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [BYTE_W-1:0] cmd_data,
    input  logic              pu_valid,
    input  logic [PU_W-1:0]   pu_ms,
    output logic              rsp_valid,
    output logic [BYTE_W-1:0] rsp_data,
    output logic              busy,
    output logic              bus_drive_low,
    input  logic              bus_in,
    output logic              strong_pu
);
    localparam int unsigned BIW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam int unsigned PCW = PU_W + $clog2(US_PER_MS + 1);
    localparam logic [BIW-1:0] LAST_BIT = BIW'(BYTE_W - 1);

    owm_seq_e          st;
    owm_op_e           op_q;
    logic [BYTE_W-1:0] sh, res, res_next;
    logic [BIW-1:0]    bit_idx;
    logic              go, use_pu;
    logic [PU_W-1:0]   pend_ms, use_ms;
    logic [PCW-1:0]    pcnt, pull_last;
    owm_slot_e         kind;
    logic              line_s, s_active, s_done, s_smp, accept, last_slot, writes;

    owm_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(bus_in), .q(line_s)
    );

    owm_slot #(.COEF(COEF)) u_slot (
        .clk(clk), .rst(rst), .us_tick(us_tick), .start(go), .kind(kind),
        .line_s(line_s), .drive_low(bus_drive_low), .active(s_active),
        .done(s_done), .smp_bit(s_smp)
    );

    assign cmd_ready = (st == SQ_IDLE);
    assign busy      = !cmd_ready;
    assign accept    = cmd_valid && cmd_ready;
    assign writes    = (owm_op_e'(cmd_op) == OP_WRITE) || (owm_op_e'(cmd_op) == OP_TOUCH);
    assign last_slot = (op_q == OP_RESET) || (bit_idx == LAST_BIT);
    assign pull_last = PCW'(use_ms) * PCW'(US_PER_MS) - 1'b1;
    assign strong_pu = (st == SQ_PULL) ||
                       (st == SQ_RUN && use_pu && bit_idx == LAST_BIT && s_active && !bus_drive_low);

    always_comb begin
        if (op_q == OP_RESET)     kind = SLOT_RST;
        else if (op_q == OP_READ) kind = SLOT_ONE;
        else                      kind = sh[bit_idx] ? SLOT_ONE : SLOT_ZERO;
    end

    always_comb begin
        res_next = res;
        if (op_q == OP_RESET) res_next = {{(BYTE_W-1){1'b0}}, s_smp};
        else                  res_next[bit_idx] = (kind == SLOT_ZERO) ? 1'b0 : s_smp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            op_q      <= OP_RESET;
            sh        <= '0;
            res       <= '0;
            bit_idx   <= '0;
            go        <= 1'b0;
            use_pu    <= 1'b0;
            use_ms    <= '0;
            pend_ms   <= '0;
            pcnt      <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            go        <= 1'b0;
            rsp_valid <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (accept) begin
                        st      <= SQ_RUN;
                        op_q    <= owm_op_e'(cmd_op);
                        sh      <= cmd_data;
                        res     <= '0;
                        bit_idx <= '0;
                        go      <= 1'b1;
                        use_pu  <= writes && (pend_ms != '0);
                        use_ms  <= pend_ms;
                        if (writes) pend_ms <= '0;
                    end else if (pu_valid) begin
                        pend_ms <= pu_ms;
                    end
                end
                SQ_RUN: begin
                    if (s_done) begin
                        res <= res_next;
                        if (last_slot) begin
                            if (use_pu) begin
                                st   <= SQ_PULL;
                                pcnt <= '0;
                            end else begin
                                st        <= SQ_IDLE;
                                rsp_valid <= 1'b1;
                                rsp_data  <= (op_q == OP_WRITE) ? '0 : res_next;
                            end
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            go      <= 1'b1;
                        end
                    end
                end
                SQ_PULL: begin
                    if (us_tick) begin
                        if (pcnt == pull_last) begin
                            st        <= SQ_IDLE;
                            rsp_valid <= 1'b1;
                            rsp_data  <= (op_q == OP_WRITE) ? '0 : res;
                        end else begin
                            pcnt <= pcnt + 1'b1;
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // R9: pull-up and active drive never overlap
    p_spu_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(bus_drive_low && strong_pu));

    // R7: an accepted command makes the block busy on the next cycle
    p_accept_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> busy);

    // R8: the response strobe coincides with the end of busy
    p_rsp_at_end_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (!busy && $past(busy)));

    p_end_gives_rsp_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> rsp_valid);

    // R10: a running pull-up hold has already spent the pending request
    p_pu_spent_r10: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_PULL) |-> (pend_ms == '0));
endmodule

// File: tb/owm_master_test.sv
module owm_master_test;
    import owm_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       us_tick = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] cmd_data = 8'h00;
    logic       pu_valid = 1'b0;
    logic [7:0] pu_ms = 8'h00;
    logic       cmd_ready, rsp_valid, busy, bus_drive_low, strong_pu;
    logic [7:0] rsp_data;
    logic       dev_low = 1'b0;
    logic       bus_in;

    logic       cmd_ready2, rsp_valid2, busy2, drive2, spu2;
    logic [7:0] rsp_data2;

    always #5 clk = ~clk;

    assign bus_in = !(bus_drive_low || dev_low);

    owm_master uut (
        .clk(clk), .rst(rst), .us_tick(us_tick), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .pu_valid(pu_valid), .pu_ms(pu_ms), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .busy(busy), .bus_drive_low(bus_drive_low),
        .bus_in(bus_in), .strong_pu(strong_pu)
    );

    owm_master #(.COEF(2)) uut2 (
        .clk(clk), .rst(rst), .us_tick(us_tick), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready2), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .pu_valid(1'b0), .pu_ms(8'h00), .rsp_valid(rsp_valid2),
        .rsp_data(rsp_data2), .busy(busy2), .bus_drive_low(drive2),
        .bus_in(!drive2), .strong_pu(spu2)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // monitors, sampled on the falling edge
    int lw [0:15];
    int nlow = 0, run = 0, busy_cnt = 0, spu_cnt = 0, overlap = 0, rsp_cnt = 0;
    int run2 = 0, first2 = 0, busy2_cnt = 0;
    logic [7:0] last_rsp = 8'h00;

    // device model
    logic [7:0] dev_byte = 8'hFF;
    bit  dev_present = 1'b1;
    int  since = 0, slot_n = 0, low_run = 0;
    logic prev_drv = 1'b0;

    always @(negedge clk) begin
        if (bus_drive_low) run++;
        else if (run > 0) begin
            if (nlow < 16) lw[nlow] = run;
            nlow++;
            run = 0;
        end
        if (busy) busy_cnt++;
        if (strong_pu) spu_cnt++;
        if (strong_pu && bus_drive_low) overlap++;
        if (rsp_valid) begin rsp_cnt++; last_rsp = rsp_data; end
        if (drive2) run2++;
        else if (run2 > 0) begin
            if (first2 == 0) first2 = run2;
            run2 = 0;
        end
        if (busy2) busy2_cnt++;

        if (bus_drive_low && !prev_drv) begin
            since = 0; slot_n++; low_run = 0;
        end else since++;
        if (bus_drive_low) low_run++;
        prev_drv = bus_drive_low;
        if (low_run >= 400)
            dev_low = dev_present && since >= 520 && since <= 620;
        else if (slot_n >= 1 && slot_n <= 8)
            dev_low = !dev_byte[slot_n-1] && since >= 1 && since <= 30;
        else
            dev_low = 1'b0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        nlow = 0; run = 0; busy_cnt = 0; spu_cnt = 0; rsp_cnt = 0;
        slot_n = 0; low_run = 0;
        run2 = 0; first2 = 0; busy2_cnt = 0;
    endtask

    task automatic arm(input logic [7:0] ms);
        @(negedge clk);
        pu_valid = 1'b1; pu_ms = ms;
        @(negedge clk);
        pu_valid = 1'b0;
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [7:0] d);
        while (!cmd_ready) @(negedge clk);
        clear_mon();
        cmd_op = op; cmd_data = d; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (rsp_cnt == 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // {op[2], data[8], dev[8], present[1], expected[8]}
    localparam logic [26:0] VEC [0:6] = '{
        {2'd0, 8'h00, 8'hFF, 1'b1, 8'h00},
        {2'd0, 8'h00, 8'hFF, 1'b0, 8'h01},
        {2'd2, 8'h00, 8'hA5, 1'b1, 8'hA5},
        {2'd2, 8'h00, 8'h3C, 1'b1, 8'h3C},
        {2'd1, 8'h96, 8'h00, 1'b1, 8'h00},
        {2'd3, 8'hF0, 8'h5A, 1'b1, 8'h50},
        {2'd3, 8'h0F, 8'hFF, 1'b1, 8'h0F}
    };

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(cmd_ready == 1'b1 && busy == 1'b0, "R7", int'(busy), 0);
        chk(bus_drive_low == 1'b0 && strong_pu == 1'b0 && rsp_valid == 1'b0, "R8", int'(bus_drive_low), 0);

        for (int v = 0; v < 7; v++) begin
            logic [1:0] op;
            logic [7:0] d, exp;
            op = VEC[v][26:25]; d = VEC[v][24:17];
            dev_byte = VEC[v][16:9]; dev_present = VEC[v][8]; exp = VEC[v][7:0];
            run_cmd(op, d);
            chk(last_rsp == exp, (op == 2'd0) ? "R1" : (op == 2'd2) ? "R4" : (op == 2'd1) ? "R5" : "R6",
                int'(last_rsp), int'(exp));
            chk(rsp_cnt == 1, "R8", rsp_cnt, 1);
            if (op == 2'd0) begin
                chk(nlow == 1 && lw[0] == 500, "R1", lw[0], 500);
                chk(busy_cnt == 1001, "R2", busy_cnt, 1001);
            end else begin
                chk(busy_cnt == 568, "R2", busy_cnt, 568);
                chk(nlow == 8, "R3", nlow, 8);
                for (int b = 0; b < 8; b++) begin
                    int ew;
                    ew = (op == 2'd2 || d[b]) ? 6 : 60;
                    chk(lw[b] == ew, (op == 2'd1) ? "R5" : "R3", lw[b], ew);
                end
            end
            chk(spu_cnt == 0, "R10", spu_cnt, 0);
        end

        // commands while busy are ignored
        dev_byte = 8'hFF;
        while (!cmd_ready) @(negedge clk);
        clear_mon();
        cmd_op = 2'd1; cmd_data = 8'h00; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_op = 2'd2; cmd_data = 8'hFF;
        repeat (100) @(negedge clk);
        chk(cmd_ready == 1'b0, "R7", int'(cmd_ready), 0);
        cmd_valid = 1'b0;
        while (rsp_cnt == 0) @(negedge clk);
        repeat (300) @(negedge clk);
        chk(nlow == 8 && rsp_cnt == 1, "R7", nlow, 8);
        chk(lw[7] == 60, "R7", lw[7], 60);

        // coefficient scaling, second instance
        while (!(cmd_ready && cmd_ready2)) @(negedge clk);
        clear_mon();
        cmd_op = 2'd1; cmd_data = 8'h00; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy2) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(first2 == 120, "R11", first2, 120);
        chk(busy2_cnt == 8 * 141, "R11", busy2_cnt, 8 * 141);
        chk(lw[0] == 60, "R11", lw[0], 60);

        // strong pull-up on the next write
        arm(8'd1);
        run_cmd(2'd1, 8'h80);
        chk(spu_cnt == 1064, "R9", spu_cnt, 1064);
        chk(busy_cnt == 568 + 1000, "R9", busy_cnt, 1568);
        chk(overlap == 0, "R9", overlap, 0);
        chk(last_rsp == 8'h00, "R5", int'(last_rsp), 0);
        // one-shot: spent
        run_cmd(2'd1, 8'h80);
        chk(spu_cnt == 0 && busy_cnt == 568, "R10", spu_cnt, 0);
        // read and reset leave it pending
        arm(8'd1);
        run_cmd(2'd2, 8'h00);
        chk(spu_cnt == 0, "R10", spu_cnt, 0);
        dev_present = 1'b1;
        run_cmd(2'd0, 8'h00);
        chk(spu_cnt == 0, "R10", spu_cnt, 0);
        run_cmd(2'd3, 8'h7F);
        chk(spu_cnt == 10 + 1000, "R9", spu_cnt, 1010);
        chk(last_rsp == 8'h7F, "R6", int'(last_rsp), 8'h7F);
        // zero cancels
        arm(8'd1);
        arm(8'd0);
        run_cmd(2'd1, 8'hFF);
        chk(spu_cnt == 0 && busy_cnt == 568, "R10", spu_cnt, 0);
        chk(overlap == 0, "R9", overlap, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule